// File: doc/BRIEF.md
# Framebuffer RAM Address Controller

This block shares one external video SRAM between two users. While the picture is visible, a scan counter steps through RAM one word per pixel tick. Pixel data therefore comes out of memory in strict order, with no holes at line ends. While either sync is active, the RAM address pins carry a pointer that the host controls instead, and the host may write pixel words through to memory.

The host supplies the horizontal sync, vertical sync and a pixel tick (sampled on the system clock). It talks to the block over a 12-bit data bus with a strobe, a two-bit select and a read/write line. With the strobe high and the read/write line low, the host can:

- load either 12-bit half of the 24-bit pointer;
- add a 12-bit stride to the pointer to reach the next line;
- store a data word at the pointer, which then advances by one.

The scan counter returns to zero at the start of every vertical sync, so each frame begins at address zero.

Top module: `fb_addr_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the scan counter and the host pointer, and deasserts `ram_we` and `busy`.
- R2: When `hsync` and `vsync` are both low and `dot_tick` is high, the scan counter advances by one on the clock edge. The new value is visible on `ram_addr` while video stays active.
- R3: While `hsync` or `vsync` is high, the scan counter holds its value whatever `dot_tick` does.
- R4: On the first clock at which `vsync` is sampled high after being low, the scan counter clears to zero.
- R5: `ram_addr` shows the scan counter when both syncs are low, and shows the host pointer when either sync is high.
- R6: A host command with `host_sel`=1 loads bits 11:0 of the pointer from `host_data`, and `host_sel`=2 loads bits 23:12. The other half of the pointer is kept.
- R7: A command with `host_sel`=3 adds the zero-extended `host_data` to the pointer, modulo 2^24.
- R8: A command with `host_sel`=0 during blanking produces a write on the next cycle. In that cycle `ram_we` and `ram_dq_oe` are high, `ram_oe` is low, `ram_addr` is the old pointer and `ram_dq_out` is the data word. The pointer then increments by one.
- R9: A `host_sel`=0 command while both syncs are low performs no write and leaves the pointer unchanged. It raises `busy` for the following cycle.
- R10: Commands with `host_rnw` high, or with `host_stb` low, have no effect on the pointer or on RAM.
- R11: `ram_we` is high only while `hsync` or `vsync` is high, and `ram_oe` is low exactly when `ram_we` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync | input | 1 | Horizontal sync, high while active |
| vsync | input | 1 | Vertical sync, high while active |
| dot_tick | input | 1 | Pixel tick enable |
| host_stb | input | 1 | Host command strobe |
| host_rnw | input | 1 | High marks a read cycle, which is ignored |
| host_sel | input | 2 | Command select: 0 write, 1 low load, 2 high load, 3 add |
| host_data | input | 12 | Host data bus |
| ram_addr | output | 24 | RAM address |
| ram_we | output | 1 | RAM write enable, active high |
| ram_oe | output | 1 | RAM output enable, active high |
| ram_dq_out | output | 12 | Data driven to RAM |
| ram_dq_oe | output | 1 | High while the block drives the RAM data bus |
| busy | output | 1 | One-cycle flag for a write refused during active video |

## Verification
On every cycle, the assertions check the following:

- the address steps by one or holds during active video, according to the pixel tick;
- a write is refused with `busy` during active video and granted during blanking;
- `ram_we` never appears outside blanking, and the RAM data bus and output enable are never driven in conflict.

Some behaviour only the bench scenarios can show, because the scan counter is hidden while its value is not on the pins:

- pointer contents after half loads, stride adds and 24-bit wraparound;
- scan values preserved across a blanking interval;
- the clear at the vertical sync edge.

The bench checks these against a behavioural model on every clock.

// File: rtl/fb_addr_ctrl.sv
module fb_addr_ctrl #(
  parameter int AW = 24,
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hsync,
  input  logic          vsync,
  input  logic          dot_tick,
  input  logic          host_stb,
  input  logic          host_rnw,
  input  logic [1:0]    host_sel,
  input  logic [DW-1:0] host_data,
  output logic [AW-1:0] ram_addr,
  output logic          ram_we,
  output logic          ram_oe,
  output logic [DW-1:0] ram_dq_out,
  output logic          ram_dq_oe,
  output logic          busy
);
  localparam int HW = AW - DW;

  logic [AW-1:0] scan_q, ptr_q, waddr_q;
  logic [DW-1:0] wdata_q;
  logic          we_q, busy_q, vs_q;
  logic          blank, cmd, vs_rise;

  assign blank   = hsync | vsync;
  assign cmd     = host_stb & ~host_rnw;
  assign vs_rise = vsync & ~vs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scan_q <= '0;
      vs_q   <= 1'b0;
    end else begin
      vs_q <= vsync;
      if (vs_rise)
        scan_q <= '0;
      else if (dot_tick && !blank)
        scan_q <= scan_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q   <= '0;
      waddr_q <= '0;
      wdata_q <= '0;
      we_q    <= 1'b0;
      busy_q  <= 1'b0;
    end else begin
      we_q   <= 1'b0;
      busy_q <= 1'b0;
      if (cmd) begin
        unique case (host_sel)
          2'd0: if (blank) begin
                  we_q    <= 1'b1;
                  waddr_q <= ptr_q;
                  wdata_q <= host_data;
                  ptr_q   <= ptr_q + 1'b1;
                end else begin
                  busy_q  <= 1'b1;
                end
          2'd1: ptr_q[DW-1:0]  <= host_data;
          2'd2: ptr_q[AW-1:DW] <= host_data[HW-1:0];
          2'd3: ptr_q <= ptr_q + {{HW{1'b0}}, host_data};
        endcase
      end
    end
  end

  assign ram_we     = we_q & blank;
  assign ram_oe     = ~ram_we;
  assign ram_dq_oe  = ram_we;
  assign ram_dq_out = wdata_q;
  assign busy       = busy_q;
  assign ram_addr   = !blank ? scan_q : (ram_we ? waddr_q : ptr_q);
endmodule

module fb_addr_ctrl_chk #(
  parameter int AW = 24,
  parameter int DW = 12
) (
  input logic          clk,
  input logic          rst,
  input logic          hsync,
  input logic          vsync,
  input logic          dot_tick,
  input logic          host_stb,
  input logic          host_rnw,
  input logic [1:0]    host_sel,
  input logic [AW-1:0] ram_addr,
  input logic          ram_we,
  input logic          ram_oe,
  input logic          ram_dq_oe,
  input logic          busy
);
  logic act;
  assign act = !hsync && !vsync;

  a_r1_reset_clear: assert property (@(posedge clk) rst |=> !ram_we && !busy);

  a_r2_scan_step: assert property (@(posedge clk) disable iff (rst)
    (act && dot_tick) |=> (!act || ram_addr == $past(ram_addr) + 1'b1));

  a_r3_scan_hold: assert property (@(posedge clk) disable iff (rst)
    (act && !dot_tick) |=> (!act || ram_addr == $past(ram_addr)));

  a_r9_refuse: assert property (@(posedge clk) disable iff (rst)
    (act && host_stb && !host_rnw && host_sel == 2'd0) |=> busy && !ram_we);

  a_r8_grant: assert property (@(posedge clk) disable iff (rst)
    (!act && host_stb && !host_rnw && host_sel == 2'd0) |=> !busy && (ram_we == (hsync || vsync)));

  a_r11_we_blank: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> (hsync || vsync) && !ram_oe && ram_dq_oe);
endmodule

bind fb_addr_ctrl fb_addr_ctrl_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .hsync(hsync), .vsync(vsync), .dot_tick(dot_tick),
  .host_stb(host_stb), .host_rnw(host_rnw), .host_sel(host_sel),
  .ram_addr(ram_addr), .ram_we(ram_we), .ram_oe(ram_oe),
  .ram_dq_oe(ram_dq_oe), .busy(busy)
);

// File: tb/tb_fb_addr_ctrl.sv
module tb_fb_addr_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hsync = 1'b0, vsync = 1'b0, dot_tick = 1'b0;
  logic        host_stb = 1'b0, host_rnw = 1'b0;
  logic [1:0]  host_sel = 2'd0;
  logic [11:0] host_data = '0;
  logic [23:0] ram_addr;
  logic        ram_we, ram_oe, ram_dq_oe, busy;
  logic [11:0] ram_dq_out;

  int checks = 0, errors = 0;
  int m_scan, m_ptr, m_waddr, m_wdata;
  bit m_we, m_busy, m_vsq;

  always #10 clk = ~clk;

  fb_addr_ctrl dut (
    .clk(clk), .rst(rst), .hsync(hsync), .vsync(vsync), .dot_tick(dot_tick),
    .host_stb(host_stb), .host_rnw(host_rnw), .host_sel(host_sel),
    .host_data(host_data), .ram_addr(ram_addr), .ram_we(ram_we),
    .ram_oe(ram_oe), .ram_dq_out(ram_dq_out), .ram_dq_oe(ram_dq_oe), .busy(busy)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic model_step();
    bit blank;
    blank = hsync || vsync;
    if (rst) begin
      m_scan = 0; m_ptr = 0; m_we = 0; m_busy = 0; m_vsq = 0;
      m_waddr = 0; m_wdata = 0;
      return;
    end
    if (vsync && !m_vsq) m_scan = 0;
    else if (dot_tick && !blank) m_scan = (m_scan + 1) % (1 << 24);
    m_vsq = vsync;
    m_we = 0; m_busy = 0;
    if (host_stb && !host_rnw) begin
      case (host_sel)
        2'd0: if (blank) begin
                m_we = 1; m_waddr = m_ptr; m_wdata = host_data;
                m_ptr = (m_ptr + 1) % (1 << 24);
              end else m_busy = 1;
        2'd1: m_ptr = (m_ptr & 32'hFFF000) | host_data;
        2'd2: m_ptr = (m_ptr & 32'h000FFF) | (int'(host_data) << 12);
        default: m_ptr = (m_ptr + host_data) % (1 << 24);
      endcase
    end
  endtask

  task automatic compare();
    bit blank, ewe;
    int eaddr;
    blank = hsync || vsync;
    ewe = m_we && blank;
    eaddr = !blank ? m_scan : (ewe ? m_waddr : m_ptr);
    chk("R5 addr", ram_addr, eaddr);
    chk("R11 we", ram_we, ewe);
    chk("R11 oe", ram_oe, !ewe);
    chk("R8 dq_oe", ram_dq_oe, ewe);
    if (ewe) chk("R8 dq", ram_dq_out, m_wdata);
    chk("R9 busy", busy, m_busy);
  endtask

  task automatic cyc(input bit hs, input bit vs, input bit dt, input bit stb,
                     input bit rnw, input logic [1:0] sel, input logic [11:0] d);
    hsync = hs; vsync = vs; dot_tick = dt;
    host_stb = stb; host_rnw = rnw; host_sel = sel; host_data = d;
    @(posedge clk);
    model_step();
    @(negedge clk);
    hsync = hs; vsync = vs;
    compare();
  endtask

  task automatic idle(input bit hs, input bit vs, input bit dt);
    cyc(hs, vs, dt, 1'b0, 1'b0, 2'd0, 12'h0);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    rst = 1'b1;
    repeat (3) idle(0, 0, 1);
    rst = 1'b0;
    chk("R1 reset addr", ram_addr, 0);
    chk("R1 reset we", ram_we, 0);
    chk("R1 reset busy", busy, 0);

    for (int i = 0; i < 10; i++) idle(0, 0, i[0]);
    chk("R2 scan after 5 ticks", ram_addr, 5);
    for (int i = 0; i < 3; i++) idle(0, 0, 1);
    chk("R2 scan after 8 ticks", ram_addr, 8);

    for (int i = 0; i < 4; i++) idle(1, 0, 1);
    idle(0, 0, 0);
    chk("R3 scan held over hsync", ram_addr, 8);

    cyc(1, 0, 0, 1, 0, 2'd1, 12'h345);
    cyc(1, 0, 0, 1, 0, 2'd2, 12'h012);
    chk("R6 half loads", ram_addr, 24'h012345);
    cyc(1, 0, 0, 1, 0, 2'd3, 12'h0FF);
    chk("R7 stride add", ram_addr, 24'h012444);

    cyc(1, 0, 0, 1, 0, 2'd0, 12'hABC);
    chk("R8 write addr", ram_addr, 24'h012444);
    chk("R8 write we", ram_we, 1);
    chk("R8 write data", ram_dq_out, 12'hABC);
    chk("R8 oe low", ram_oe, 0);
    idle(1, 0, 0);
    chk("R8 ptr increment", ram_addr, 24'h012445);

    cyc(1, 0, 0, 1, 1, 2'd1, 12'h000);
    cyc(1, 0, 0, 0, 0, 2'd3, 12'h111);
    cyc(1, 0, 0, 1, 1, 2'd0, 12'h555);
    chk("R10 ignored ptr", ram_addr, 24'h012445);
    chk("R10 ignored we", ram_we, 0);

    cyc(1, 0, 0, 1, 0, 2'd2, 12'hFFF);
    cyc(1, 0, 0, 1, 0, 2'd1, 12'hFFF);
    cyc(1, 0, 0, 1, 0, 2'd3, 12'h002);
    chk("R7 wrap", ram_addr, 24'h000001);

    cyc(0, 0, 1, 1, 0, 2'd0, 12'h777);
    chk("R9 busy raised", busy, 1);
    chk("R9 no we", ram_we, 0);
    idle(1, 0, 0);
    chk("R9 busy pulse ends", busy, 0);
    chk("R9 ptr unchanged", ram_addr, 24'h000001);

    idle(0, 0, 1);
    chk("R2 resumed", ram_addr, 10);
    idle(0, 1, 1);
    idle(0, 1, 1);
    idle(0, 0, 0);
    chk("R4 frame clear", ram_addr, 0);
    cyc(0, 1, 0, 1, 0, 2'd0, 12'h0F0);
    chk("R11 write in vsync", ram_we, 1);
    idle(0, 0, 1);
    chk("R11 no we in video", ram_we, 0);
    for (int i = 0; i < 20; i++) cyc(i % 7 == 0, i % 11 == 0, 1, 1, 0, 2'(i), 12'(i * 37));

    rst = 1'b1;
    idle(1, 0, 1);
    rst = 1'b0;
    idle(1, 0, 0);
    chk("R1 reset ptr", ram_addr, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule